// File: doc/BRIEF.md
# Receive Character Handoff with Status Flags

This block sits between a serial receive engine and a processor bus. The engine hands over each finished character. The block keeps the character in a data register and raises a data-available flag. Beside it the block keeps a status register, and a status-available flag tells the processor when a new condition has appeared. The processor has two read strobes. One takes the data register and the other takes the status register.

The status register has five bits:

| Bit | Meaning |
|-----|---------|
| 0 | Start of message (SOM) |
| 1 | End of message (EOM) |
| 2 | Overrun (OVR) |
| 3 | Error (ERR) |
| 4 | Short final character (SHORT) |

Only the receive engine sets or clears the start-of-message bit. A read of the status register leaves it alone, and it never raises status-available. Every other status bit raises status-available when it goes from 0 to 1. A status read clears that bit and clears the flag.

A character that finishes while the data register is still unread waits in a one-entry hold stage. If the processor reads the data register before the next receive-clock tick, the waiting character moves in and nothing is lost. If the tick comes first, the block sets the overrun bit and drops the waiting character. It then drops every further character until the processor reads the data register again. A character marked as the last one of a message is never overrun, however long it waits. When it enters the data register it sets end-of-message, so data-available and status-available rise in the same cycle.

Top module: `rx_handoff`

## Requirements
- R1: After reset, `rx_da`, `rx_sa`, `rx_data` and all of `rx_status` are 0.
- R2: When a character enters the data register, `rx_data` shows it and `rx_da` is 1 from the next cycle on. A `rd_data` pulse with no character waiting and none arriving clears `rx_da` on the next cycle.
- R3: `rx_sa` becomes 1 in the same cycle as any status bit 1 to 4 goes from 0 to 1. A change of bit 0 (SOM) never sets `rx_sa`.
- R4: A `rd_stat` pulse clears `rx_sa` and status bits 1 to 4 on the next cycle, and bit 0 keeps its value. A bit that is set in the same cycle as the read is left at 1, and then `rx_sa` is also 1.
- R5: `som_set` sets status bit 0 and `som_clr` clears it. If both are asserted together, `som_set` wins. No other input changes bit 0.
- R6: A character that arrives while `rx_da` is 1 and unread is held. If `rd_data` comes before the next `rck_tick`, the held character appears on `rx_data`, `rx_da` stays 1 and status bit 2 stays 0.
- R7: When `rck_tick` comes while an unprotected character is held and the data register is unread, status bit 2 (OVR) is set and the held character is discarded. Every character that arrives after that is discarded until the next `rd_data`.
- R8: A held character marked with `chr_last` is never discarded by `rck_tick`. When it enters the data register, status bit 1 (EOM) is set, and `rx_da` and `rx_sa` rise in the same cycle.
- R9: A character marked with `chr_short` sets status bit 4 when it enters the data register.
- R10: If a character arrives while the data register is unread and the hold stage is already full, the new character is dropped and status bit 2 (OVR) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| chr_valid | input | 1 | Receive engine delivers a finished character |
| chr_data | input | DW | The delivered character |
| chr_last | input | 1 | The character is the final one of the message |
| chr_short | input | 1 | The character is shorter than the set length |
| rck_tick | input | 1 | One-cycle strobe for each receive-clock period |
| som_set | input | 1 | Engine sets start-of-message |
| som_clr | input | 1 | Engine clears start-of-message |
| err_set | input | 1 | Engine reports a check error |
| rd_data | input | 1 | Processor reads the data register |
| rd_stat | input | 1 | Processor reads the status register |
| rx_data | output | DW | Data register |
| rx_da | output | 1 | Data-available flag |
| rx_status | output | 5 | Status register (bit meanings listed above) |
| rx_sa | output | 1 | Status-available flag |

## Verification

The bench covers the grace window in both directions:
- A read that arrives just before a tick must keep the held character. A design that checks for overrun too early would drop it.
- A tick with no read must set overrun and discard. A design that checks too late would let a stale byte through, and data would keep flowing after the loss.

The protected last character is made to wait across several ticks. A design without this protection flags overrun at the end of a message and never reports end-of-message.

Other corner cases are a status read in the same cycle as a new error, and repeated status reads while start-of-message is set. The first catches a design that drops the new error. The second catches a design that clears start-of-message or raises status-available on it.

A long random phase follows, compared cycle by cycle with a reference model. It mixes reads, ticks and bursts of characters, and catches ordering slips between the hold stage and the data register.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
    localparam int SW       = 5;
    localparam int SB_SOM   = 0;
    localparam int SB_EOM   = 1;
    localparam int SB_OVR   = 2;
    localparam int SB_ERR   = 3;
    localparam int SB_SHORT = 4;
endpackage

// File: rtl/rxh_char_path.sv
module rxh_char_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_data_i,
    input  logic          chr_valid_i,
    input  logic [DW-1:0] chr_data_i,
    input  logic          chr_last_i,
    input  logic          chr_short_i,
    input  logic          rck_tick_i,
    output logic [DW-1:0] data_o,
    output logic          da_o,
    output logic          ld_o,
    output logic          ld_last_o,
    output logic          ld_short_o,
    output logic          ovr_o
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          da;
        logic          pv;
        logic [DW-1:0] pdata;
        logic          plast;
        logic          pshort;
        logic          lose;
    } cp_t;

    cp_t  q, d;
    logic occ;

    always_comb begin
        d          = q;
        ld_o       = 1'b0;
        ld_last_o  = 1'b0;
        ld_short_o = 1'b0;
        ovr_o      = 1'b0;
        occ        = q.da & ~rd_data_i;
        if (rd_data_i) begin
            d.lose = 1'b0;
        end
        if (q.pv) begin
            if (!occ) begin
                d.data     = q.pdata;
                d.pv       = 1'b0;
                occ        = 1'b1;
                ld_o       = 1'b1;
                ld_last_o  = q.plast;
                ld_short_o = q.pshort;
            end else if (rck_tick_i && !q.plast) begin
                d.pv   = 1'b0;
                d.lose = 1'b1;
                ovr_o  = 1'b1;
            end
        end
        if (chr_valid_i && !d.lose) begin
            if (!occ) begin
                d.data     = chr_data_i;
                occ        = 1'b1;
                ld_o       = 1'b1;
                ld_last_o  = chr_last_i;
                ld_short_o = chr_short_i;
            end else if (!d.pv) begin
                d.pv     = 1'b1;
                d.pdata  = chr_data_i;
                d.plast  = chr_last_i;
                d.pshort = chr_short_i;
            end else begin
                d.lose = 1'b1;
                ovr_o  = 1'b1;
            end
        end
        d.da = occ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o = q.data;
    assign da_o   = q.da;

    AST_DA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_i && !chr_valid_i && !q.pv |=> !da_o); // R2
    AST_LAST_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        q.pv && q.plast && rck_tick_i && !chr_valid_i |-> !ovr_o); // R8
    AST_LOSS_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        q.lose && !rd_data_i && !q.pv |=> $stable(data_o)); // R7
endmodule

// File: rtl/rxh_status.sv
module rxh_status
    import rxh_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stat_i,
    input  logic          som_set_i,
    input  logic          som_clr_i,
    input  logic          err_set_i,
    input  logic          ld_i,
    input  logic          ld_last_i,
    input  logic          ld_short_i,
    input  logic          ovr_i,
    output logic [SW-1:0] stat_o,
    output logic          sa_o
);
    localparam logic [SW-1:0] SOM_M = SW'(1) << SB_SOM;

    typedef struct packed {
        logic [SW-1:0] stat;
        logic          sa;
    } st_t;

    st_t           q, d;
    logic [SW-1:0] base, setv, rise;

    always_comb begin
        base            = rd_stat_i ? (q.stat & SOM_M) : q.stat;
        setv            = '0;
        setv[SB_EOM]    = ld_i & ld_last_i;
        setv[SB_OVR]    = ovr_i;
        setv[SB_ERR]    = err_set_i;
        setv[SB_SHORT]  = ld_i & ld_short_i;
        rise            = setv & ~base & ~SOM_M;
        d.stat          = base | setv;
        if (som_clr_i) begin
            d.stat[SB_SOM] = 1'b0;
        end
        if (som_set_i) begin
            d.stat[SB_SOM] = 1'b1;
        end
        d.sa = (q.sa & ~rd_stat_i) | (|rise);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stat_o = q.stat;
    assign sa_o   = q.sa;

    AST_EOM_RAISES_SA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[SB_EOM]) |-> sa_o); // R3
    AST_SOM_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_i && !som_set_i && !som_clr_i |=> $stable(stat_o[SB_SOM])); // R5
    AST_READ_CLEARS_SA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_i && !err_set_i && !ovr_i && !ld_i |=> !sa_o); // R4
endmodule

// File: rtl/rx_handoff.sv
module rx_handoff
    import rxh_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_valid,
    input  logic [DW-1:0] chr_data,
    input  logic          chr_last,
    input  logic          chr_short,
    input  logic          rck_tick,
    input  logic          som_set,
    input  logic          som_clr,
    input  logic          err_set,
    input  logic          rd_data,
    input  logic          rd_stat,
    output logic [DW-1:0] rx_data,
    output logic          rx_da,
    output logic [SW-1:0] rx_status,
    output logic          rx_sa
);
    logic ld, ld_last, ld_short, ovr;

    rxh_char_path #(.DW(DW)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_data_i   (rd_data),
        .chr_valid_i (chr_valid),
        .chr_data_i  (chr_data),
        .chr_last_i  (chr_last),
        .chr_short_i (chr_short),
        .rck_tick_i  (rck_tick),
        .data_o      (rx_data),
        .da_o        (rx_da),
        .ld_o        (ld),
        .ld_last_o   (ld_last),
        .ld_short_o  (ld_short),
        .ovr_o       (ovr)
    );

    rxh_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stat_i  (rd_stat),
        .som_set_i  (som_set),
        .som_clr_i  (som_clr),
        .err_set_i  (err_set),
        .ld_i       (ld),
        .ld_last_i  (ld_last),
        .ld_short_i (ld_short),
        .ovr_i      (ovr),
        .stat_o     (rx_status),
        .sa_o       (rx_sa)
    );

    AST_OVR_RAISES_SA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_status[SB_OVR]) |-> rx_sa); // R7
    AST_LOAD_SETS_DA: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> rx_da); // R2
endmodule

// File: tb/tb_rx_handoff.sv
module tb_rx_handoff;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chr_valid = 0, chr_last = 0, chr_short = 0, rck_tick = 0;
    logic          som_set = 0, som_clr = 0, err_set = 0, rd_data = 0, rd_stat = 0;
    logic [DW-1:0] chr_data = '0;
    logic [DW-1:0] rx_data;
    logic          rx_da, rx_sa;
    logic [4:0]    rx_status;

    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    rx_handoff #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_last(chr_last), .chr_short(chr_short), .rck_tick(rck_tick),
        .som_set(som_set), .som_clr(som_clr), .err_set(err_set),
        .rd_data(rd_data), .rd_stat(rd_stat), .rx_data(rx_data), .rx_da(rx_da),
        .rx_status(rx_status), .rx_sa(rx_sa)
    );

    // reference model: held characters kept in a queue of {last, short, data}
    logic [DW+1:0] m_hold[$];
    logic [DW-1:0] m_data;
    logic          m_da, m_sa, m_lose;
    logic [4:0]    m_stat;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold.delete();
            m_data = '0; m_da = 0; m_sa = 0; m_lose = 0; m_stat = '0;
        end else begin
            logic       busy;
            logic [4:0] nb, newbits;
            newbits = '0;
            busy = m_da && !rd_data;
            if (rd_data) m_lose = 0;
            if (m_hold.size() > 0) begin
                if (!busy) begin
                    m_data = m_hold[0][DW-1:0];
                    if (m_hold[0][DW+1]) newbits[1] = 1;
                    if (m_hold[0][DW]) newbits[4] = 1;
                    void'(m_hold.pop_front());
                    busy = 1;
                end else if (rck_tick && !m_hold[0][DW+1]) begin
                    m_hold.delete();
                    m_lose = 1;
                    newbits[2] = 1;
                end
            end
            if (chr_valid && !m_lose) begin
                if (!busy) begin
                    m_data = chr_data;
                    if (chr_last) newbits[1] = 1;
                    if (chr_short) newbits[4] = 1;
                    busy = 1;
                end else if (m_hold.size() == 0) begin
                    m_hold.push_back({chr_last, chr_short, chr_data});
                end else begin
                    m_lose = 1;
                    newbits[2] = 1;
                end
            end
            m_da = busy;
            if (err_set) newbits[3] = 1;
            nb = rd_stat ? {4'b0, m_stat[0]} : m_stat;
            if (rd_stat) m_sa = 0;
            for (int i = 1; i < 5; i++)
                if (newbits[i] && !nb[i]) m_sa = 1;
            nb = nb | newbits;
            if (som_clr) nb[0] = 0;
            if (som_set) nb[0] = 1;
            m_stat = nb;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(rx_da === m_da, "R2", "da", int'(rx_da), int'(m_da));
        chk(rx_data === m_data, "R2", "data", int'(rx_data), int'(m_data));
        chk(rx_status === m_stat, "R4", "status", int'(rx_status), int'(m_stat));
        chk(rx_sa === m_sa, "R3", "sa", int'(rx_sa), int'(m_sa));
    endtask

    task automatic step(input logic cv, input logic [DW-1:0] cd, input logic cl,
                        input logic cs, input logic tk, input logic rdd,
                        input logic rds, input logic ss, input logic sc,
                        input logic es);
        chr_valid = cv; chr_data = cd; chr_last = cl; chr_short = cs;
        rck_tick = tk; rd_data = rdd; rd_stat = rds;
        som_set = ss; som_clr = sc; err_set = es;
        @(posedge clk);
        @(negedge clk);
        chr_valid = 0; rck_tick = 0; rd_data = 0; rd_stat = 0;
        som_set = 0; som_clr = 0; err_set = 0; chr_last = 0; chr_short = 0;
        compare();
    endtask

    task automatic chr(input logic [DW-1:0] v, input logic last, input logic sh);
        step(1, v, last, sh, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rdd();  step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0); endtask
    task automatic rds();  step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0); endtask
    task automatic tick(); step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rx_da == 0 && rx_sa == 0 && rx_status == 0 && rx_data == 0, "R1",
            "reset", int'({rx_da, rx_sa, rx_status}), 0);
        rst_n = 1;
        @(negedge clk);

        chr(8'hA5, 0, 0);
        chk(rx_da && rx_data == 8'hA5, "R2", "load", int'(rx_data), 8'hA5);
        rdd();
        chk(!rx_da, "R2", "read clears da", int'(rx_da), 0);

        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk(rx_status[0] && !rx_sa, "R5", "som set no sa", int'({rx_status[0], rx_sa}), 2);
        rds();
        chk(rx_status[0] == 1, "R4", "som kept on read", int'(rx_status[0]), 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        chk(rx_status[0] == 1, "R5", "set wins over clear", int'(rx_status[0]), 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        chk(rx_status[0] == 0, "R5", "som clear", int'(rx_status[0]), 0);

        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk(rx_sa && rx_status[3], "R3", "err raises sa", int'(rx_sa), 1);
        rds();
        chk(!rx_sa && rx_status == 0, "R4", "read clears", int'(rx_status), 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1);
        chk(rx_sa && rx_status[3], "R4", "set beats read", int'(rx_sa), 1);
        rds();

        chr(8'h11, 0, 0);
        chr(8'h22, 0, 0);
        chk(rx_data == 8'h11, "R6", "first stays", int'(rx_data), 8'h11);
        rdd();
        chk(rx_da && rx_data == 8'h22 && !rx_status[2], "R6", "held moves in",
            int'(rx_data), 8'h22);
        rdd();

        chr(8'h33, 0, 0);
        chr(8'h44, 0, 0);
        tick();
        chk(rx_status[2] && rx_sa, "R7", "overrun set", int'(rx_status), 4);
        chr(8'h55, 0, 0);
        chk(rx_data == 8'h33, "R7", "later char lost", int'(rx_data), 8'h33);
        rdd();
        chk(!rx_da, "R7", "held discarded", int'(rx_da), 0);
        chr(8'h66, 0, 0);
        chk(rx_data == 8'h66, "R7", "flow resumes", int'(rx_data), 8'h66);
        rdd();
        rds();

        chr(8'h70, 0, 0);
        chr(8'h07, 1, 1);
        tick(); tick(); tick();
        chk(!rx_status[2] && !rx_sa, "R8", "last not overrun", int'(rx_status), 0);
        rdd();
        chk(rx_da && rx_sa && rx_data == 8'h07 && rx_status[1], "R8",
            "eom with da and sa", int'(rx_status), 5'h12);
        chk(rx_status[4], "R9", "short bit", int'(rx_status[4]), 1);
        rdd();
        rds();

        chr(8'h81, 0, 0);
        chr(8'h82, 0, 0);
        chr(8'h83, 0, 0);
        chk(rx_status[2] && rx_data == 8'h81, "R10", "third char overruns",
            int'(rx_status), 4);
        rdd();
        chk(rx_data == 8'h82, "R10", "held survives", int'(rx_data), 8'h82);
        rdd();
        rds();

        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 4) == 0, 8'($urandom), ($urandom % 8) == 0,
                 ($urandom % 8) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
                 ($urandom % 5) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
                 ($urandom % 20) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule